// File: doc/BRIEF.md
# CPU Clock Divider with Wake-up Hold-off

This block turns one free-running oscillator clock into a set of single-cycle enables, so that all downstream logic stays in the oscillator domain and is gated by these enables instead of by derived clocks. A programmable divider produces the CPU clock enable. The divide factor is twice an 8-bit register value, or no division at all when the value is zero. Two further strobes follow at half the CPU rate: a peripheral clock enable and a machine-cycle strobe. A gated clock output pin toggles once per CPU clock.

After reset, and again after each wake request, the block keeps the CPU clock enable low until a fixed number of oscillator cycles has elapsed, and only then raises its ready flag. Software may rewrite the divider value at any moment. The new value is held pending and is applied only when the current division period ends, so no CPU clock period is ever shortened or split.

Top module: `cpu_clock_gen`

## Requirements
- R1: While rst_n is low, clk_ready, cclk_en, pclk_en, mcyc_stb and clk_out are all 0, and the divider value returns to zero.
- R2: After rst_n rises, clk_ready is first observed high after exactly 224 oscillator rising edges. cclk_en is never high while clk_ready is low.
- R3: A wake_req sampled high drops clk_ready at the next edge and restarts the full 224-cycle hold-off. The CPU clock enable then stays off until clk_ready returns.
- R4: With a divider value of 0, cclk_en is high on every oscillator cycle once ready.
- R5: With a nonzero divider value N (1..255), cclk_en pulses once every 2*N oscillator cycles. The largest value gives a period of 510 cycles.
- R6: A value written on div_wr does not alter the period that is in progress. It applies from the first period that starts after the next cclk_en pulse, and each period is the full length of either the old or the new setting.
- R7: pclk_en is high on every second cclk_en pulse, starting with the first pulse after clk_ready rises.
- R8: mcyc_stb is high on the cclk_en pulses that pclk_en skips, so one machine cycle spans two CPU clocks. pclk_en and mcyc_stb are never high together, and neither is high without cclk_en.
- R9: While clkout_en is 1, clk_out inverts on the edge that ends each cclk_en cycle, giving half the CPU clock rate. One edge after clkout_en is 0, clk_out is 0 and stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Selected oscillator clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| div_wr | input | 1 | Write strobe for the divider value |
| div_wdata | input | 8 | New divider value N (0 = no division, else divide by 2*N) |
| clkout_en | input | 1 | Enables the toggling clock output pin |
| wake_req | input | 1 | Restarts the wake-up hold-off |
| cclk_en | output | 1 | CPU clock enable, one oscillator cycle wide |
| pclk_en | output | 1 | Peripheral clock enable at half the CPU rate |
| mcyc_stb | output | 1 | Machine-cycle strobe, on the second CPU clock of each pair |
| clk_out | output | 1 | Clock output at half the CPU clock rate |
| clk_ready | output | 1 | High once the hold-off has elapsed |

## Verification
The enables are combinational from registered state, so cclk_en, pclk_en and mcyc_stb are valid in the same cycle as the counter state that causes them. clk_ready and clk_out change one edge after the event that drives them: reset release and wake_req need 224 edges, and a clock-output change needs one. A new divider value appears only after the current period ends, so the bench waits out more than the longest period before it measures. It then counts oscillator edges between consecutive pulses. All sampling takes place on the falling edge, half a cycle after the rising edge that updates the state, and every expected count is derived from the edge arithmetic above rather than from the design.

// File: rtl/cpu_clock_gen_pkg.sv
// Package: shared constants and helpers for the CPU clock generator.
// Assumes the divider register is at most 15 bits wide so periods fit in an int.
package cpu_clock_gen_pkg;
    localparam int unsigned DEF_DIV_W       = 8;
    localparam int unsigned DEF_HOLD_CYCLES = 224;

    // Width of a counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/cgen_wake_timer.sv
// Module: wake-up hold-off counter.
// Loads HOLD_CYCLES on reset or on a wake request and counts down once per
// oscillator cycle; ready is high only when the count has reached zero.
// Assumes wake_req is already synchronous to clk_osc.
module cgen_wake_timer #(
    parameter int unsigned HOLD_CYCLES = 224
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic wake_req,
    output logic ready
);
    localparam int unsigned HW = cpu_clock_gen_pkg::cnt_width(HOLD_CYCLES);

    generate
        if (HOLD_CYCLES == 0) begin : g_no_hold
            logic rdy_q;
            // Purpose: ready follows reset only when no hold-off is configured.
            always_ff @(posedge clk_osc) begin
                if (!rst_n) rdy_q <= 1'b0;
                else        rdy_q <= 1'b1;
            end
            assign ready = rdy_q;
        end else begin : g_hold
            logic [HW-1:0] remain_q;
            // Purpose: reload on reset or wake, otherwise count down to zero.
            always_ff @(posedge clk_osc) begin
                if (!rst_n || wake_req)  remain_q <= HW'(HOLD_CYCLES);
                else if (remain_q != '0) remain_q <= remain_q - HW'(1);
            end
            assign ready = (remain_q == '0);
        end
    endgenerate
endmodule

// File: rtl/cgen_divider.sv
// Module: programmable CPU clock divider.
// A written value is parked in a pending register and moved into the active
// register only at a terminal count (or while the clock is held off), so a
// period in progress always completes with its original length.
// Value 0 gives a tick every cycle; value N gives a tick every 2*N cycles.
module cgen_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             ready,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    output logic             tick
);
    localparam int unsigned CW = DIV_W + 1;

    logic [DIV_W-1:0] pending_q;
    logic [DIV_W-1:0] active_q;
    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    term;

    // Purpose: last cycle of the division period for the active value.
    always_comb begin
        if (active_q == '0) term = '0;
        else                term = {active_q, 1'b0} - CW'(1);
    end

    assign tick = ready && (cnt_q == term);

    // Purpose: capture software writes without disturbing the running period.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)      pending_q <= '0;
        else if (div_wr) pending_q <= div_wdata;
    end

    // Purpose: adopt the pending value only at a period boundary.
    always_ff @(posedge clk_osc) begin
        if (!rst_n)              active_q <= '0;
        else if (!ready || tick) active_q <= pending_q;
    end

    // Purpose: position within the current division period.
    always_ff @(posedge clk_osc) begin
        if (!rst_n || !ready || tick) cnt_q <= '0;
        else                          cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/cgen_phase.sv
// Module: half-rate strobes and clock output derived from the CPU tick.
// A phase bit alternates on each tick: the first tick of a pair is the
// peripheral enable, the second ends the machine cycle. The output pin
// inverts on each tick while enabled and is forced low otherwise.
module cgen_phase (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic ready,
    input  logic tick,
    input  logic clkout_en,
    output logic pclk_en,
    output logic mcyc_stb,
    output logic clk_out
);
    logic second_q;
    logic pin_q;

    // Purpose: track which CPU clock of the pair comes next.
    always_ff @(posedge clk_osc) begin
        if (!rst_n || !ready) second_q <= 1'b0;
        else if (tick)        second_q <= ~second_q;
    end

    assign pclk_en  = tick && !second_q;
    assign mcyc_stb = tick &&  second_q;

    // Purpose: toggle the output pin once per CPU clock while enabled.
    always_ff @(posedge clk_osc) begin
        if (!rst_n || !clkout_en) pin_q <= 1'b0;
        else if (tick)            pin_q <= ~pin_q;
    end

    assign clk_out = pin_q;
endmodule

// File: rtl/cpu_clock_gen.sv
// Module: top of the CPU clock generator.
// Combines the wake-up hold-off, the divider and the phase logic. All outputs
// are enables in the clk_osc domain; no derived clock nets are created.
// Assumes every input is synchronous to clk_osc.
module cpu_clock_gen #(
    parameter int unsigned DIV_W       = cpu_clock_gen_pkg::DEF_DIV_W,
    parameter int unsigned HOLD_CYCLES = cpu_clock_gen_pkg::DEF_HOLD_CYCLES
) (
    input  logic             clk_osc,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_wdata,
    input  logic             clkout_en,
    input  logic             wake_req,
    output logic             cclk_en,
    output logic             pclk_en,
    output logic             mcyc_stb,
    output logic             clk_out,
    output logic             clk_ready
);
    logic ready_w;
    logic tick_w;

    cgen_wake_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_wake (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .wake_req(wake_req),
        .ready   (ready_w)
    );

    cgen_divider #(.DIV_W(DIV_W)) u_div (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .ready    (ready_w),
        .div_wr   (div_wr),
        .div_wdata(div_wdata),
        .tick     (tick_w)
    );

    cgen_phase u_phase (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .ready    (ready_w),
        .tick     (tick_w),
        .clkout_en(clkout_en),
        .pclk_en  (pclk_en),
        .mcyc_stb (mcyc_stb),
        .clk_out  (clk_out)
    );

    assign cclk_en   = tick_w;
    assign clk_ready = ready_w;
endmodule

// File: rtl/cpu_clock_gen_chk.sv
// Module: property checker for cpu_clock_gen, attached by bind.
module cpu_clock_gen_chk (
    input logic clk_osc,
    input logic rst_n,
    input logic clkout_en,
    input logic wake_req,
    input logic cclk_en,
    input logic pclk_en,
    input logic mcyc_stb,
    input logic clk_out,
    input logic clk_ready
);
    // R2
    no_tick_unready_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !clk_ready |-> !cclk_en);

    // R3
    wake_drops_ready_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        wake_req |=> !clk_ready);

    // R8
    strobes_exclusive_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !(pclk_en && mcyc_stb));

    // R8
    strobe_needs_tick_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (pclk_en || mcyc_stb) |-> cclk_en);

    // R9
    pin_low_when_off_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !clkout_en |=> !clk_out);

    // R9
    pin_toggles_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (clkout_en && cclk_en) |=> (clk_out != $past(clk_out)));
endmodule

bind cpu_clock_gen cpu_clock_gen_chk u_chk (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .clkout_en(clkout_en),
    .wake_req (wake_req),
    .cclk_en  (cclk_en),
    .pclk_en  (pclk_en),
    .mcyc_stb (mcyc_stb),
    .clk_out  (clk_out),
    .clk_ready(clk_ready)
);

// File: tb/cpu_clock_gen_tb.sv
module cpu_clock_gen_tb;
    logic       clk_osc = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_wr = 1'b0;
    logic [7:0] div_wdata = '0;
    logic       clkout_en = 1'b0;
    logic       wake_req = 1'b0;
    logic       cclk_en, pclk_en, mcyc_stb, clk_out, clk_ready;

    int n_checks = 0;
    int n_fails  = 0;

    localparam int NVEC = 6;
    localparam int unsigned VEC_N   [NVEC] = '{0, 1, 2, 5, 255, 128};
    localparam int unsigned VEC_PER [NVEC] = '{1, 2, 4, 10, 510, 256};

    always #4 clk_osc = ~clk_osc;

    cpu_clock_gen u_dut (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .div_wr   (div_wr),
        .div_wdata(div_wdata),
        .clkout_en(clkout_en),
        .wake_req (wake_req),
        .cclk_en  (cclk_en),
        .pclk_en  (pclk_en),
        .mcyc_stb (mcyc_stb),
        .clk_out  (clk_out),
        .clk_ready(clk_ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_div(input logic [7:0] v);
        div_wdata = v;
        div_wr    = 1'b1;
        @(negedge clk_osc);
        div_wr    = 1'b0;
    endtask

    // Edges from one cclk_en pulse to the next, sampled on falling edges.
    task automatic measure(output int p);
        while (!cclk_en) @(negedge clk_osc);
        p = 0;
        do begin
            @(negedge clk_osc);
            p++;
        end while (!cclk_en);
    endtask

    initial begin
        #1_500_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int n, p, pc, mc, tog, hi;
        logic prev;
        // R1: outputs during reset
        repeat (4) @(negedge clk_osc);
        chk("R1 ready", int'(clk_ready), 0);
        chk("R1 enables", int'(cclk_en | pclk_en | mcyc_stb | clk_out), 0);

        // R2: hold-off after reset release
        rst_n = 1'b1;
        n = 0;
        do begin
            @(negedge clk_osc);
            n++;
        end while (!clk_ready && n < 1000);
        chk("R2 hold cycles", n, 224);
        // R7 / R4: first tick after ready is a peripheral tick, divider at 0
        chk("R7 first pclk", int'(pclk_en), 1);
        chk("R4 tick on ready", int'(cclk_en), 1);

        // R4 R5 R7 R8: vector table
        for (int i = 0; i < NVEC; i++) begin
            write_div(VEC_N[i][7:0]);
            repeat (1100) @(negedge clk_osc);
            measure(p);
            chk("R5 period", p, int'(VEC_PER[i]));
            pc = 0; mc = 0;
            for (int k = 0; k < 8; k++) begin
                if (k > 0) @(negedge clk_osc);
                while (!cclk_en) @(negedge clk_osc);
                pc += int'(pclk_en);
                mc += int'(mcyc_stb);
            end
            chk("R7 pclk count", pc, 4);
            chk("R8 mcyc count", mc, 4);
        end

        // R6: write during a period does not change it
        write_div(8'd3);
        repeat (1100) @(negedge clk_osc);
        while (!cclk_en) @(negedge clk_osc);
        n = 0;
        @(negedge clk_osc); n++;
        div_wdata = 8'd1; div_wr = 1'b1;
        @(negedge clk_osc); n++;
        div_wr = 1'b0;
        while (!cclk_en) begin
            @(negedge clk_osc); n++;
        end
        chk("R6 old period kept", n, 6);
        measure(p);
        chk("R6 new period", p, 2);

        // R9: clock output toggles per CPU clock when enabled
        write_div(8'd2);
        repeat (1100) @(negedge clk_osc);
        clkout_en = 1'b1;
        repeat (20) @(negedge clk_osc);
        tog = 0; prev = clk_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk_osc);
            if (clk_out != prev) tog++;
            prev = clk_out;
        end
        chk("R9 toggles", tog, 10);
        clkout_en = 1'b0;
        @(negedge clk_osc);
        hi = 0;
        for (int k = 0; k < 40; k++) begin
            hi += int'(clk_out);
            @(negedge clk_osc);
        end
        chk("R9 low when off", hi, 0);

        // R3: wake request restarts hold-off
        wake_req = 1'b1;
        @(negedge clk_osc);
        wake_req = 1'b0;
        chk("R3 ready drop", int'(clk_ready), 0);
        n = 0; pc = 0;
        do begin
            @(negedge clk_osc);
            n++;
            if (!clk_ready) pc += int'(cclk_en);
        end while (!clk_ready && n < 1000);
        chk("R3 hold cycles", n, 224);
        chk("R3 no tick while held", pc, 0);

        // R1: divider returns to zero on reset
        rst_n = 1'b0;
        @(negedge clk_osc);
        chk("R1 ready in reset", int'(clk_ready), 0);
        rst_n = 1'b1;
        while (!clk_ready) @(negedge clk_osc);
        measure(p);
        chk("R1 divider cleared", p, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule